// File: doc/BRIEF.md
# Page Programming Sequencer

This block drives one page write into a byte-wide, electrically erasable memory. The memory is connected through active-low chip select, read strobe and write strobe pins and a shared address/data bus. The host gives a start pulse, the page number and the number of bytes less one. The block then pulls the bytes one by one from a stream source that uses a valid/ready handshake.

Each page load starts with a fixed three-write unlock preamble. The page bytes follow in offset order, starting at offset 0. After the last byte, the block polls that byte's address until bit 7 of the read data equals bit 7 of the byte just written, and then pulses `done`.

Every interval on the memory pins is a whole number of clock cycles, set by a parameter. Two deadlines can end a run with `error` set:
- the source leaves a byte gap longer than the memory's load window allows;
- the completion poll runs past its time budget.

Top module: `page_prog_seq`

## Requirements
- R1: While reset is held, and after its release until a start, the three strobes are high, the bus is not driven, and `busy`, `done`, `error` and `src_ready` are low.
- R2: An accepted start first issues three writes, in this order: data 0xAA to address 0x5555, data 0x55 to address 0x2AAA, data 0xA0 to address 0x5555.
- R3: After the preamble, exactly `len_m1`+1 source bytes are written, in arrival order. Byte i goes to the address whose bits 16..7 hold `page_sel` and whose bits 6..0 hold i.
- R4: Each write holds chip select low with the write strobe high for `SU_CYC` cycles, drives the write strobe low for `WP_CYC` cycles, then holds it high for `WPH_CYC` cycles. Address and data stay unchanged for the whole write.
- R5: The write strobe is low only while chip select is low and the read strobe is high.
- R6: `src_ready` is high only while the block waits for a page byte, and never during a strobe. A byte is taken in a cycle where `src_valid` and `src_ready` are both high.
- R7: If no byte arrives within `LOAD_WAIT` cycles of `src_ready` rising, the run ends at once with `done` and `error`, with no further write or poll.
- R8: Polling holds the last written address with the bus released and the read strobe low for `RD_CYC` cycles. On a bit-7 mismatch it raises the read strobe for `OEH_CYC` cycles and reads again.
- R9: A run ends with `done` high for exactly one cycle, after which `busy` is low. `error` is low when the poll matched.
- R10: If polling lasts `POLL_MAX` cycles without a match, the run ends with `done` and `error` high.
- R11: A start pulse while `busy` is high is ignored: it changes neither the page nor the byte count of the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start a page load (taken when idle) |
| page_sel | input | PAGE_BITS | Page number (address bits 16..7) |
| len_m1 | input | OFS_BITS | Byte count minus one |
| src_valid | input | 1 | Source byte present |
| src_data | input | DATA_W | Source byte |
| src_ready | output | 1 | Block takes a byte this cycle |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory read strobe, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_addr | output | PAGE_BITS+OFS_BITS | Memory address |
| mem_dout | output | DATA_W | Write data to the bus |
| mem_drive | output | 1 | Bus driver enable for `mem_dout` |
| mem_din | input | DATA_W | Read data from the bus |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Last run ended on a deadline |

## Verification
The memory pins are registered from the next state, so they change on the same edge that enters a phase.

Write timing is checked phase by phase. The strobe low time is counted cycle by cycle and must equal `WP_CYC`. The bench counts the cycles from chip select falling to the first write strobe fall and expects exactly `SU_CYC`. It expects `WPH_CYC`+`SU_CYC` cycles between two preamble pulses.

Source handshake and deadlines are checked next. A byte whose valid is raised after a wait of k cycles is accepted at the end of that cycle. The stall vectors sit one cycle either side of the `LOAD_WAIT` limit.

Polling is checked last. `done` is due one cycle after the last cycle of the matching read. The bench samples every pin on the falling clock edge, counts reads and read-strobe gaps, and checks `busy` on the falling edge after `done`.

// File: rtl/page_prog_pkg.sv
// Shared types and constants for the page programming sequencer.
// Assumes address and data widths of at least 15 and 8 bits.
package page_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PULSE,
        ST_RECOV,
        ST_POLL_RD,
        ST_POLL_GAP,
        ST_FINISH
    } seq_state_e;

    // Unlock preamble address for step 0..2.
    function automatic logic [14:0] unlock_addr(input logic [1:0] step);
        case (step)
            2'd1:    unlock_addr = 15'h2AAA;
            default: unlock_addr = 15'h5555;
        endcase
    endfunction

    // Unlock preamble data for step 0..2.
    function automatic logic [7:0] unlock_data(input logic [1:0] step);
        case (step)
            2'd0:    unlock_data = 8'hAA;
            2'd1:    unlock_data = 8'h55;
            default: unlock_data = 8'hA0;
        endcase
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        max2 = (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ppg_phase_timer.sv
// Phase down-counter: loaded with (length-1) when a phase starts,
// reports expiry in the phase's last cycle. Assumes load values fit W bits.
module ppg_phase_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count down to zero, reload at each phase start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ppg_deadline.sv
// Deadline counter: counts cycles while run is high, clears when it drops,
// raises hit in the LIMIT-th consecutive run cycle. Assumes LIMIT >= 1.
module ppg_deadline #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Saturating count of consecutive run cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt != CW'(LIMIT - 1))
            cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == CW'(LIMIT - 1));

    assert_deadline_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/page_prog_seq.sv
// Page programming sequencer. On start it writes the unlock preamble, then
// len_m1+1 streamed bytes into one page, then polls bit 7 of the last byte.
// Assumes all *_CYC parameters are >= 1 and PAGE_BITS+OFS_BITS >= 15.
module page_prog_seq
    import page_prog_pkg::*;
#(
    parameter int unsigned PAGE_BITS = 10,
    parameter int unsigned OFS_BITS  = 7,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned SU_CYC    = 1,
    parameter int unsigned WP_CYC    = 50,
    parameter int unsigned WPH_CYC   = 25,
    parameter int unsigned RD_CYC    = 50,
    parameter int unsigned OEH_CYC   = 38,
    parameter int unsigned LOAD_WAIT = 36000,
    parameter int unsigned POLL_MAX  = 2500000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [PAGE_BITS-1:0]           page_sel,
    input  logic [OFS_BITS-1:0]            len_m1,
    input  logic                           src_valid,
    input  logic [DATA_W-1:0]              src_data,
    output logic                           src_ready,
    output logic                           mem_ce_n,
    output logic                           mem_oe_n,
    output logic                           mem_we_n,
    output logic [PAGE_BITS+OFS_BITS-1:0]  mem_addr,
    output logic [DATA_W-1:0]              mem_dout,
    output logic                           mem_drive,
    input  logic [DATA_W-1:0]              mem_din,
    output logic                           busy,
    output logic                           done,
    output logic                           error
);
    localparam int unsigned AW     = PAGE_BITS + OFS_BITS;
    localparam int unsigned BEAT_W = OFS_BITS + 2;
    localparam int unsigned TMAX   = max2(max2(max2(SU_CYC, WP_CYC), max2(WPH_CYC, RD_CYC)), OEH_CYC);
    localparam int unsigned TW     = $clog2(TMAX + 1);
    localparam logic [BEAT_W-1:0] CMD_BEATS = BEAT_W'(3);

    seq_state_e            state_q, state_nxt;
    logic [BEAT_W-1:0]     beat_q, beat_nxt;
    logic [BEAT_W-1:0]     last_q, last_nxt;
    logic [PAGE_BITS-1:0]  page_q, page_nxt;
    logic [AW-1:0]         addr_q, addr_nxt;
    logic [DATA_W-1:0]     data_q, data_nxt;
    logic                  err_q, err_nxt;
    logic                  tmr_load, tmr_zero;
    logic [TW-1:0]         tmr_val;
    logic                  gap_run, gap_hit, poll_run, poll_hit;
    logic                  ce_q, oe_q, we_q, drv_q;

    // Phase length counter for strobe intervals.
    ppg_phase_timer #(.W(TW)) phase_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    // Byte load window deadline while waiting on the source.
    ppg_deadline #(.LIMIT(LOAD_WAIT)) gap_dl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (gap_run),
        .hit   (gap_hit)
    );

    // Completion poll budget.
    ppg_deadline #(.LIMIT(POLL_MAX)) poll_dl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (poll_run),
        .hit   (poll_hit)
    );

    assign gap_run  = (state_q == ST_FETCH);
    assign poll_run = (state_q == ST_POLL_RD) || (state_q == ST_POLL_GAP);

    // Next-state, beat and bus value selection.
    always_comb begin
        state_nxt = state_q;
        beat_nxt  = beat_q;
        last_nxt  = last_q;
        page_nxt  = page_q;
        addr_nxt  = addr_q;
        data_nxt  = data_q;
        err_nxt   = err_q;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_nxt = ST_SETUP;
                    beat_nxt  = '0;
                    page_nxt  = page_sel;
                    last_nxt  = BEAT_W'(len_m1) + CMD_BEATS;
                    addr_nxt  = AW'(unlock_addr(2'd0));
                    data_nxt  = DATA_W'(unlock_data(2'd0));
                    err_nxt   = 1'b0;
                end
            end
            ST_FETCH: begin
                if (src_valid) begin
                    state_nxt = ST_SETUP;
                    addr_nxt  = {page_q, OFS_BITS'(beat_q - CMD_BEATS)};
                    data_nxt  = src_data;
                end else if (gap_hit) begin
                    state_nxt = ST_FINISH;
                    err_nxt   = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_zero) state_nxt = ST_PULSE;
            end
            ST_PULSE: begin
                if (tmr_zero) state_nxt = ST_RECOV;
            end
            ST_RECOV: begin
                if (tmr_zero) begin
                    if (beat_q == last_q) begin
                        state_nxt = ST_POLL_RD;
                    end else begin
                        beat_nxt = beat_q + 1'b1;
                        if (beat_nxt < CMD_BEATS) begin
                            state_nxt = ST_SETUP;
                            addr_nxt  = AW'(unlock_addr(beat_nxt[1:0]));
                            data_nxt  = DATA_W'(unlock_data(beat_nxt[1:0]));
                        end else begin
                            state_nxt = ST_FETCH;
                        end
                    end
                end
            end
            ST_POLL_RD: begin
                if (tmr_zero && (mem_din[DATA_W-1] == data_q[DATA_W-1])) begin
                    state_nxt = ST_FINISH;
                end else if (poll_hit) begin
                    state_nxt = ST_FINISH;
                    err_nxt   = 1'b1;
                end else if (tmr_zero) begin
                    state_nxt = ST_POLL_GAP;
                end
            end
            ST_POLL_GAP: begin
                if (poll_hit) begin
                    state_nxt = ST_FINISH;
                    err_nxt   = 1'b1;
                end else if (tmr_zero) begin
                    state_nxt = ST_POLL_RD;
                end
            end
            ST_FINISH: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // Phase length chosen by the phase being entered.
    always_comb begin
        tmr_load = (state_nxt != state_q);
        case (state_nxt)
            ST_SETUP:    tmr_val = TW'(SU_CYC - 1);
            ST_PULSE:    tmr_val = TW'(WP_CYC - 1);
            ST_RECOV:    tmr_val = TW'(WPH_CYC - 1);
            ST_POLL_RD:  tmr_val = TW'(RD_CYC - 1);
            ST_POLL_GAP: tmr_val = TW'(OEH_CYC - 1);
            default:     tmr_val = '0;
        endcase
    end

    // Sequencer state and held run context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            last_q  <= '0;
            page_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_nxt;
            beat_q  <= beat_nxt;
            last_q  <= last_nxt;
            page_q  <= page_nxt;
            addr_q  <= addr_nxt;
            data_q  <= data_nxt;
            err_q   <= err_nxt;
        end
    end

    // Glitch-free strobes registered from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q  <= 1'b0;
            oe_q  <= 1'b0;
            we_q  <= 1'b0;
            drv_q <= 1'b0;
        end else begin
            ce_q  <= (state_nxt != ST_IDLE) && (state_nxt != ST_FINISH);
            oe_q  <= (state_nxt == ST_POLL_RD);
            we_q  <= (state_nxt == ST_PULSE);
            drv_q <= (state_nxt == ST_FETCH) || (state_nxt == ST_SETUP) ||
                     (state_nxt == ST_PULSE) || (state_nxt == ST_RECOV);
        end
    end

    assign mem_ce_n  = !ce_q;
    assign mem_oe_n  = !oe_q;
    assign mem_we_n  = !we_q;
    assign mem_drive = drv_q;
    assign mem_addr  = addr_q;
    assign mem_dout  = data_q;
    assign src_ready = (state_q == ST_FETCH);
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_FINISH);
    assign error     = err_q;

    assert_we_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_oe_n));

    assert_bus_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_drive);

    assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> (mem_we_n || ($stable(mem_addr) && $stable(mem_dout))));

    assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (mem_we_n && mem_oe_n && busy));

    assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && beat_q >= CMD_BEATS) |-> (mem_addr[AW-1:OFS_BITS] == page_q));

    assert_done_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(page_q) && $stable(last_q)));

endmodule

// File: tb/page_prog_seq_tb_top.sv
module page_prog_seq_tb_top;

    localparam int SU  = 2;
    localparam int WP  = 6;
    localparam int WPH = 4;
    localparam int RD  = 3;
    localparam int OEH = 5;
    localparam int LW  = 20;
    localparam int PM  = 200;

    typedef struct packed {
        logic [6:0] m1;
        logic [9:0] page;
        logic [7:0] polls;
        logic [7:0] stall_at;
        logic [7:0] stall_len;
        logic       restart;
        logic       exp_err;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{7'd0,   10'h155, 8'd0, 8'd0, 8'd0,  1'b0, 1'b0},
        '{7'd3,   10'h2A0, 8'd3, 8'd2, 8'd5,  1'b1, 1'b0},
        '{7'd127, 10'h3FF, 8'd2, 8'd0, 8'd0,  1'b0, 1'b0},
        '{7'd7,   10'h001, 8'd1, 8'd0, 8'd19, 1'b0, 1'b0},
        '{7'd5,   10'h0F0, 8'd0, 8'd3, 8'd20, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  page_sel = '0;
    logic [6:0]  len_m1 = '0;
    logic        src_valid = 1'b0;
    logic [7:0]  src_data = '0;
    logic        src_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_drive;
    logic        busy, done, error;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dout, mem_din;

    int checks = 0;
    int errors = 0;

    logic [16:0] wr_addr [140];
    logic [7:0]  wr_data [140];
    int  wr_n, reads, low_bad, gap_bad, rd_bad, strobe_bad, ready_bad;
    int  pulse_idx, first_setup, second_gap, lowcnt, hi_run, oe_hi, fail_left;
    bit  seen_done, done_err, last_b7, prev_we, prev_oe;

    always #2 clk = ~clk;

    page_prog_seq #(
        .SU_CYC(SU), .WP_CYC(WP), .WPH_CYC(WPH), .RD_CYC(RD),
        .OEH_CYC(OEH), .LOAD_WAIT(LW), .POLL_MAX(PM)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .page_sel(page_sel),
        .len_m1(len_m1), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_drive(mem_drive), .mem_din(mem_din), .busy(busy),
        .done(done), .error(error)
    );

    // Memory model: bit 7 reads inverted while programming is still pending.
    assign mem_din = {((fail_left != 0) ? ~last_b7 : last_b7), 7'h00};

    // Pin monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_we && !mem_we_n) begin
                pulse_idx = pulse_idx + 1;
                if (pulse_idx == 1) first_setup = hi_run;
                if (pulse_idx == 2) second_gap = hi_run;
                lowcnt = 0;
            end
            if (!mem_we_n) lowcnt = lowcnt + 1;
            if (!prev_we && mem_we_n) begin
                if (lowcnt != WP) low_bad = low_bad + 1;
                if (!mem_ce_n && wr_n < 140) begin
                    wr_addr[wr_n] = mem_addr;
                    wr_data[wr_n] = mem_dout;
                    last_b7 = mem_dout[7];
                    wr_n = wr_n + 1;
                end
            end
            if (!mem_we_n) hi_run = 0;
            else if (!mem_ce_n && mem_oe_n && mem_drive) hi_run = hi_run + 1;
            else hi_run = 0;
            if (!mem_we_n && (mem_ce_n || !mem_oe_n)) strobe_bad = strobe_bad + 1;
            if (src_ready && (!mem_we_n || !mem_oe_n)) ready_bad = ready_bad + 1;
            if (prev_oe && !mem_oe_n) begin
                reads = reads + 1;
                if (reads > 1 && oe_hi != OEH) gap_bad = gap_bad + 1;
                if (mem_drive) rd_bad = rd_bad + 1;
            end
            if (!prev_oe && mem_oe_n && fail_left > 0) fail_left = fail_left - 1;
            if (!mem_oe_n) oe_hi = 0;
            else oe_hi = oe_hi + 1;
            if (done) begin
                seen_done = 1'b1;
                done_err = error;
            end
        end
        prev_we = mem_we_n;
        prev_oe = mem_oe_n;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int idx, input int i);
        exp_byte = 8'((idx * 37 + i * 5 + 1) & 255);
    endfunction

    task automatic run_vec(input vec_t v, input int idx, input int exp_writes,
                           input int exp_reads);
        int guard;
        int bad;
        int page_bad;
        @(negedge clk);
        wr_n = 0; reads = 0; low_bad = 0; gap_bad = 0; rd_bad = 0;
        strobe_bad = 0; ready_bad = 0; pulse_idx = 0; first_setup = 0;
        second_gap = 0; hi_run = 0; oe_hi = 0; fail_left = int'(v.polls);
        seen_done = 1'b0; done_err = 1'b0;
        start = 1'b1; page_sel = v.page; len_m1 = v.m1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i <= int'(v.m1); i++) begin
            guard = 0;
            while (!src_ready && !seen_done && guard < 5000) begin
                @(negedge clk);
                guard++;
            end
            if (seen_done || guard >= 5000) break;
            if (i == int'(v.stall_at)) repeat (int'(v.stall_len)) @(negedge clk);
            src_data = exp_byte(idx, i);
            src_valid = 1'b1;
            @(negedge clk);
            src_valid = 1'b0;
            if (v.restart && i == 0) begin
                // R11: start while busy with another page and count.
                start = 1'b1; page_sel = ~v.page; len_m1 = 7'd0;
                @(negedge clk);
                start = 1'b0;
            end
        end
        guard = 0;
        while (!seen_done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        check(!busy && !done, "R9", "busy|done after done pulse", int'({busy, done}), 0);
        check(seen_done && done_err == v.exp_err, v.exp_err ? "R7/R10" : "R9",
              "error flag at done", int'(done_err), int'(v.exp_err));
        check(wr_n == exp_writes, "R3", "write count", wr_n, exp_writes);
        bad = (wr_n < 3) ? 1 : 0;
        if (wr_n >= 3) begin
            if (wr_addr[0] != 17'h05555 || wr_data[0] != 8'hAA) bad++;
            if (wr_addr[1] != 17'h02AAA || wr_data[1] != 8'h55) bad++;
            if (wr_addr[2] != 17'h05555 || wr_data[2] != 8'hA0) bad++;
        end
        check(bad == 0, "R2", "unlock writes wrong", bad, 0);
        bad = 0;
        page_bad = 0;
        for (int k = 3; k < wr_n; k++) begin
            if (wr_addr[k] != {v.page, 7'(k - 3)} || wr_data[k] != exp_byte(idx, k - 3)) bad++;
            if (wr_addr[k][16:7] != v.page) page_bad++;
        end
        check(bad == 0, "R3", "page bytes wrong", bad, 0);
        if (v.restart) check(page_bad == 0, "R11", "page changed by start", page_bad, 0);
        check(low_bad == 0, "R4", "strobe low width mismatches", low_bad, 0);
        check(first_setup == SU, "R4", "setup cycles", first_setup, SU);
        check(second_gap == WPH + SU, "R4", "high cycles between pulses", second_gap, WPH + SU);
        check(strobe_bad == 0, "R5", "illegal strobe cycles", strobe_bad, 0);
        check(ready_bad == 0, "R6", "ready during strobe", ready_bad, 0);
        if (exp_reads >= 0) check(reads == exp_reads, "R8", "poll reads", reads, exp_reads);
        check(gap_bad == 0 && rd_bad == 0, "R8", "poll gap/bus faults", gap_bad + rd_bad, 0);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        vec_t pt;
        repeat (4) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_drive && !busy && !done && !error && !src_ready,
              "R1", "outputs in reset", 0, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_ce_n && mem_oe_n && mem_we_n && !mem_drive && !busy && !done && !error && !src_ready,
              "R1", "outputs idle after reset", 0, 1);

        // Table walk.
        for (int n = 0; n < 5; n++) begin
            run_vec(VECS[n], n,
                    VECS[n].exp_err ? 3 + int'(VECS[n].stall_at) : int'(VECS[n].m1) + 4,
                    VECS[n].exp_err ? 0 : int'(VECS[n].polls) + 1);
        end

        // R10: the memory never finishes, the poll budget runs out.
        pt = '{7'd0, 10'h0AA, 8'd255, 8'd0, 8'd0, 1'b0, 1'b1};
        run_vec(pt, 9, 4, -1);
        check(reads >= 2, "R10", "retries before timeout", reads, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule